// File: doc/BRIEF.md
# Indirect Buffer Entry Fetcher

This block takes 64-bit indirect-buffer entries from a host-side producer, works out from each one a 40-bit byte start address and a length in 32-bit words, and turns the entry into a run of memory read requests, one per word. Read data coming back in order is tagged with the byte address it was read from and handed to a downstream command decoder through a valid/ready word port.

Entries arrive in batches; the producer marks the final entry of a batch. Ordinary entries are fetched ahead of the decoder, so up to a fixed number of words may already be in flight while earlier words are still waiting to be consumed. An entry whose sync-wait flag is set turns off this read-ahead for itself and for every later entry of the same batch: such entries are only started once every word before them has been accepted downstream. The next batch starts with read-ahead allowed again. A halt input lets the surrounding logic stop the fetcher between segments.

Top module: `ib_fetcher`

## Requirements
- R1: The start byte address is {high[7:0], low[31:2], 2'b00}, where low is ent_data_i[31:0] and high is ent_data_i[63:32]; low bits 1:0 and high bits 9:8 have no effect on any request address or word.
- R2: An entry issues exactly high[30:10] read requests, at the start address plus 4 times the word index, in increasing order.
- R3: Words are delivered downstream in issue order, each with word_data_o equal to the memory response for that read and word_addr_o equal to its request address.
- R4: An entry of length zero issues no read, delivers no word, and is removed from the entry queue without waiting for the downstream side.
- R5: An entry with high[31] = 1 issues its first read only after every word of all earlier entries has been accepted downstream (word_valid_o and word_ready_i both high).
- R6: Every entry after a sync-flagged entry in the same batch (a batch ends with an entry pushed with ent_last_i = 1) obeys the rule of R5; the first entry of the following batch is read ahead again.
- R7: Entries without the R5/R6 restriction are read without waiting for the downstream side, until DATA_DEPTH + 1 words are held unaccepted.
- R8: While halt_i is 1 no new entry is started; a segment already issuing runs to its last request; clearing halt_i resumes fetching.
- R9: While word_valid_o is 1 and word_ready_i is 0, word_valid_o, word_data_o and word_addr_o stay unchanged in the next cycle.
- R10: After reset, word_valid_o and mem_req_valid_o are 0 and ent_ready_o is 1.
- R11: ent_ready_o goes to 0 once ENT_DEPTH entries are waiting, and pushes are only accepted while it is 1.
- R12: The number of words requested but not yet accepted downstream never exceeds DATA_DEPTH + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Hold off starting new entries |
| ent_valid_i | input | 1 | Entry push request |
| ent_data_i | input | 64 | Entry, high word in bits 63:32 |
| ent_last_i | input | 1 | Pushed entry ends its batch |
| ent_ready_o | output | 1 | Entry queue has room |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_addr_o | output | 40 | Byte address of the read |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | In-order read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| word_valid_o | output | 1 | Word for the decoder valid |
| word_data_o | output | 32 | Command word |
| word_addr_o | output | 40 | Byte address of the command word |
| word_ready_i | input | 1 | Decoder accepts the word |

## Verification
A pushed entry is registered into the queue on the edge it is accepted, may start on the next edge and then presents its first request one cycle later; a response written into the word buffer reaches the registered word port one edge after it lands. Rather than predicting exact arrival cycles under randomised memory and decoder backpressure, the bench counts request and word handshakes at the clock edge, compares each against an address list built from the entry fields, and checks the read-ahead rules at the moment a restricted entry's first request is accepted. Settled-state checks (halt, zero length, queue full, read-ahead depth) are taken after enough idle cycles for every register on the path to have updated, sampled on the falling edge.

// File: rtl/ib_fetch_pkg.sv
package ib_fetch_pkg;

  localparam int ADDR_W = 40;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 21;
  localparam int ENT_W  = 64;

  // Bit layout of one entry as it arrives on the push port.
  typedef struct packed {
    logic              sync_wait;   // 63
    logic [LEN_W-1:0]  length;      // 62:42
    logic              sub_level;   // 41
    logic              priv;        // 40
    logic [7:0]        addr_hi;     // 39:32
    logic [29:0]       addr_lo;     // 31:2
    logic              rsvd;        // 1
    logic              cond_fetch;  // 0
  } raw_entry_t;

  // What the fetcher keeps of an entry once it has been queued.
  typedef struct packed {
    logic              read_ahead;
    logic [LEN_W-1:0]  length;
    logic [ADDR_W-1:0] start;
  } seg_desc_t;

  function automatic logic [ADDR_W-1:0] seg_start(input raw_entry_t e);
    return {e.addr_hi, e.addr_lo, 2'b00};
  endfunction

endpackage

// File: rtl/ib_sync_fifo.sv
module ib_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [WIDTH-1:0]               wdata,
  input  logic                           pop,
  output logic [WIDTH-1:0]               rdata,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  // Storage without reset so it maps onto distributed or block RAM.
  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign rdata = store[rd_ptr];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt_q != CW'(DEPTH)));
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/ib_batch_gate.sv
module ib_batch_gate (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic sync_wait,
  input  logic last,
  output logic read_ahead
);
  // Set once a sync-flagged entry has been taken in the current batch.
  logic closed_q;

  assign read_ahead = !sync_wait && !closed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      closed_q <= 1'b0;
    end else if (accept) begin
      if (last)           closed_q <= 1'b0;
      else if (sync_wait) closed_q <= 1'b1;
    end
  end

  assert_batch_reopen_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && last) |=> !closed_q);

endmodule

// File: rtl/ib_seg_issue.sv
module ib_seg_issue
  import ib_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_i,
  input  logic              head_valid_i,
  input  seg_desc_t         head_i,
  input  logic              drained_i,
  input  logic              credit_ok_i,
  input  logic              req_ready_i,
  output logic              head_pop_o,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  logic              run_q;
  logic              ahead_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              zero_len;
  logic              may_start;
  logic              req_fire;

  assign zero_len   = (head_i.length == '0);
  assign may_start  = zero_len || head_i.read_ahead || drained_i;
  assign head_pop_o = !run_q && head_valid_i && !halt_i && may_start;
  assign req_valid_o = run_q && credit_ok_i;
  assign req_addr_o  = addr_q;
  assign req_fire    = req_valid_o && req_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      ahead_q <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
    end else if (!run_q) begin
      if (head_pop_o && !zero_len) begin
        run_q   <= 1'b1;
        ahead_q <= head_i.read_ahead;
        addr_q  <= head_i.start;
        rem_q   <= head_i.length;
      end
    end else if (req_fire) begin
      addr_q <= addr_q + ADDR_W'(4);
      rem_q  <= rem_q - LEN_W'(1);
      if (rem_q == LEN_W'(1)) run_q <= 1'b0;
    end
  end

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (req_fire && rem_q > LEN_W'(1)) |=> (req_addr_o == $past(req_addr_o) + ADDR_W'(4)));
  assert_no_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (rem_q != '0));
  assert_wait_drain_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(run_q) && !ahead_q) |-> $past(drained_i));
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (halt_i && !run_q) |=> !run_q);

endmodule

// File: rtl/ib_fetcher.sv
module ib_fetcher
  import ib_fetch_pkg::*;
#(
  parameter int ENT_DEPTH  = 4,
  parameter int DATA_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_i,
  input  logic              ent_valid_i,
  input  logic [63:0]       ent_data_i,
  input  logic              ent_last_i,
  output logic              ent_ready_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [ADDR_W-1:0] word_addr_o,
  input  logic              word_ready_i
);
  localparam int EC_W  = $clog2(ENT_DEPTH + 1);
  localparam int DC_W  = $clog2(DATA_DEPTH + 1);
  localparam int SEG_W = $bits(seg_desc_t);
  localparam int BUF_W = ADDR_W + WORD_W;

  // ---------------- entry decode and queue ----------------
  raw_entry_t raw;
  seg_desc_t  in_desc, head_desc;
  logic       ent_full, ent_empty, ent_accept, ent_pop, read_ahead;
  logic [EC_W-1:0] ent_cnt;
  logic       unused_fields;

  assign raw           = raw_entry_t'(ent_data_i);
  assign unused_fields = ^{raw.cond_fetch, raw.rsvd, raw.priv, raw.sub_level, ent_cnt};
  assign ent_ready_o   = !ent_full;
  assign ent_accept    = ent_valid_i && !ent_full;

  ib_batch_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .accept     (ent_accept),
    .sync_wait  (raw.sync_wait),
    .last       (ent_last_i),
    .read_ahead (read_ahead)
  );

  always_comb begin
    in_desc.read_ahead = read_ahead;
    in_desc.length     = raw.length;
    in_desc.start      = seg_start(raw);
  end

  logic [SEG_W-1:0] head_bits;

  ib_sync_fifo #(.WIDTH(SEG_W), .DEPTH(ENT_DEPTH)) u_entq (
    .clk   (clk),
    .rst   (rst),
    .push  (ent_accept),
    .wdata (in_desc),
    .pop   (ent_pop),
    .rdata (head_bits),
    .empty (ent_empty),
    .full  (ent_full),
    .count (ent_cnt)
  );
  assign head_desc = seg_desc_t'(head_bits);

  // ---------------- issue and in-flight bookkeeping ----------------
  logic              tag_empty, tag_full, buf_empty, buf_full;
  logic [DC_W-1:0]   tag_cnt, buf_cnt;
  logic [DC_W:0]     inflight;
  logic              credit_ok, drained, req_fire;
  logic [ADDR_W-1:0] tag_head;
  logic [BUF_W-1:0]  buf_head;
  logic              unused_flags;
  logic              out_load;
  logic              out_valid_q;
  logic [WORD_W-1:0] out_data_q;
  logic [ADDR_W-1:0] out_addr_q;

  assign inflight  = {1'b0, tag_cnt} + {1'b0, buf_cnt};
  assign credit_ok = inflight < (DC_W + 1)'(DATA_DEPTH);
  assign drained   = tag_empty && buf_empty && !out_valid_q;
  assign req_fire  = mem_req_valid_o && mem_req_ready_i;
  assign unused_flags = ^{tag_full, buf_full};

  ib_seg_issue u_issue (
    .clk          (clk),
    .rst          (rst),
    .halt_i       (halt_i),
    .head_valid_i (!ent_empty),
    .head_i       (head_desc),
    .drained_i    (drained),
    .credit_ok_i  (credit_ok),
    .req_ready_i  (mem_req_ready_i),
    .head_pop_o   (ent_pop),
    .req_valid_o  (mem_req_valid_o),
    .req_addr_o   (mem_req_addr_o)
  );

  // Addresses of requests whose data has not returned yet.
  ib_sync_fifo #(.WIDTH(ADDR_W), .DEPTH(DATA_DEPTH)) u_tagq (
    .clk   (clk),
    .rst   (rst),
    .push  (req_fire),
    .wdata (mem_req_addr_o),
    .pop   (mem_rsp_valid_i),
    .rdata (tag_head),
    .empty (tag_empty),
    .full  (tag_full),
    .count (tag_cnt)
  );

  // Returned words with their addresses, waiting for the output register.
  ib_sync_fifo #(.WIDTH(BUF_W), .DEPTH(DATA_DEPTH)) u_wordq (
    .clk   (clk),
    .rst   (rst),
    .push  (mem_rsp_valid_i),
    .wdata ({tag_head, mem_rsp_data_i}),
    .pop   (out_load),
    .rdata (buf_head),
    .empty (buf_empty),
    .full  (buf_full),
    .count (buf_cnt)
  );

  // ---------------- registered word port ----------------
  assign out_load = !buf_empty && (!out_valid_q || word_ready_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_addr_q  <= '0;
    end else if (out_load) begin
      out_valid_q <= 1'b1;
      out_addr_q  <= buf_head[BUF_W-1:WORD_W];
      out_data_q  <= buf_head[WORD_W-1:0];
    end else if (word_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign word_valid_o = out_valid_q;
  assign word_data_o  = out_data_q;
  assign word_addr_o  = out_addr_q;

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (word_valid_o && !word_ready_i) |=>
      (word_valid_o && $stable(word_data_o) && $stable(word_addr_o)));
  assert_rsp_has_tag_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid_i |-> !tag_empty);
  assert_credit_bound_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o |-> (inflight < (DC_W + 1)'(DATA_DEPTH)));

endmodule

// File: tb/sim_ib_fetcher.sv
`timescale 1ns/1ps
module sim_ib_fetcher;
  localparam int ENT_DEPTH  = 4;
  localparam int DATA_DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt_i = 1'b0;
  logic        ent_valid_i = 1'b0;
  logic [63:0] ent_data_i = '0;
  logic        ent_last_i = 1'b0;
  logic        ent_ready_o;
  logic        mem_req_valid_o;
  logic [39:0] mem_req_addr_o;
  logic        mem_req_ready_i;
  logic        mem_rsp_valid_i;
  logic [31:0] mem_rsp_data_i;
  logic        word_valid_o;
  logic [31:0] word_data_o;
  logic [39:0] word_addr_o;
  logic        word_ready_i = 1'b0;

  always #2 clk = ~clk;

  ib_fetcher #(.ENT_DEPTH(ENT_DEPTH), .DATA_DEPTH(DATA_DEPTH)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  int issued = 0;
  int delivered = 0;
  logic [39:0] exp_addr[$];
  int          gated_start[$];
  bit          batch_closed = 0;
  int          rdy_mode = 1;   // 0 low, 1 high, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] mem_word(input logic [39:0] a);
    return a[31:0] ^ {a[39:32], 24'h0} ^ 32'h1357_9BDF;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: accepts with a pseudo-random ready, answers two cycles later.
  logic        p1_v;
  logic [39:0] p1_a;
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      p1_v <= 1'b0; p1_a <= '0;
      mem_rsp_valid_i <= 1'b0; mem_rsp_data_i <= '0;
      mem_req_ready_i <= 1'b0;
    end else begin
      p1_v <= mem_req_valid_o && mem_req_ready_i;
      p1_a <= mem_req_addr_o;
      mem_rsp_valid_i <= p1_v;
      mem_rsp_data_i  <= mem_word(p1_a);
      mem_req_ready_i <= lfsr[0] | lfsr[3];
    end
  end

  always @(negedge clk)
    if (rdy_mode != 2) word_ready_i = (rdy_mode == 1);
    else               word_ready_i = lfsr[1] | lfsr[5];

  // Handshake monitor.
  logic        stall_q = 1'b0;
  logic [39:0] stall_a;
  logic [31:0] stall_d;
  always @(posedge clk) begin
    if (!rst) begin
      if (stall_q) begin
        check(word_valid_o && word_addr_o == stall_a && word_data_o == stall_d,
              "R9 held word", {24'h0, word_addr_o}, {24'h0, stall_a});
      end
      stall_q <= word_valid_o && !word_ready_i;
      stall_a <= word_addr_o;
      stall_d <= word_data_o;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (issued < exp_addr.size())
          check(mem_req_addr_o == exp_addr[issued], "R1 R2 request address",
                {24'h0, mem_req_addr_o}, {24'h0, exp_addr[issued]});
        else
          check(1'b0, "R2 extra request", 64'(issued), 64'(exp_addr.size()));
        if (gated_start.size() > 0 && gated_start[0] == issued) begin
          check(delivered == issued, "R5 R6 drained before gated entry",
                64'(delivered), 64'(issued));
          void'(gated_start.pop_front());
        end
        check(issued - delivered <= DATA_DEPTH, "R12 in-flight bound",
              64'(issued - delivered + 1), 64'(DATA_DEPTH + 1));
        issued++;
      end
      if (word_valid_o && word_ready_i) begin
        if (delivered < exp_addr.size())
          check(word_addr_o == exp_addr[delivered] && word_data_o == mem_word(exp_addr[delivered]),
                "R3 word", {word_data_o, 24'h0, word_addr_o[7:0]},
                {mem_word(exp_addr[delivered]), 24'h0, exp_addr[delivered][7:0]});
        else
          check(1'b0, "R3 extra word", 64'(delivered), 64'(exp_addr.size()));
        delivered++;
      end
    end
  end

  task automatic note_entry(input logic [31:0] lo, input logic [31:0] hi, input bit last);
    logic [39:0] start;
    int len;
    bit ahead;
    start = {hi[7:0], lo[31:2], 2'b00};
    len   = int'(hi[30:10]);
    ahead = !hi[31] && !batch_closed;
    if (last) batch_closed = 0;
    else if (hi[31]) batch_closed = 1;
    if (!ahead && len > 0) gated_start.push_back(exp_addr.size());
    for (int k = 0; k < len; k++) exp_addr.push_back(start + 40'(4 * k));
  endtask

  task automatic push(input logic [31:0] lo, input logic [31:0] hi, input bit last);
    do @(negedge clk); while (!ent_ready_o);
    ent_valid_i = 1'b1; ent_data_i = {hi, lo}; ent_last_i = last;
    note_entry(lo, hi, last);
    @(negedge clk);
    ent_valid_i = 1'b0;
  endtask

  function automatic logic [31:0] mk_hi(input bit sync, input int len, input logic [1:0] side, input logic [7:0] ah);
    return {sync, 21'(len), side, ah};
  endfunction

  task automatic wait_drain();
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (delivered == exp_addr.size() && issued == exp_addr.size()) break;
    end
    check(delivered == exp_addr.size(), "R3 all words delivered",
          64'(delivered), 64'(exp_addr.size()));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(word_valid_o == 0, "R10 word_valid after reset", 64'(word_valid_o), 0);
    check(mem_req_valid_o == 0, "R10 req_valid after reset", 64'(mem_req_valid_o), 0);
    check(ent_ready_o == 1, "R10 ent_ready after reset", 64'(ent_ready_o), 1);

    // Sweep of lengths, side bits, address bytes, sync flags and batch ends.
    rdy_mode = 2;
    for (int ln = 0; ln < 6; ln++)
      for (int v = 0; v < 4; v++)
        push({30'(ln * 30'h111 + v * 30'h3_0001 + 30'h100), 2'(v)},
             mk_hi(((ln + v) % 3) == 0, ln, 2'(3 - v), 8'(v * 8'h45 + ln)), v == 3);
    wait_drain();

    // R1: side bits must not move the address.
    push({30'h0ABC_DE0, 2'b11}, mk_hi(0, 2, 2'b11, 8'hF0), 1);
    wait_drain();
    check(exp_addr[exp_addr.size()-2] == 40'hF0_02AF_3780, "R1 hand-computed start",
          {24'h0, exp_addr[exp_addr.size()-2]}, 64'hF0_02AF_3780);

    // R4: zero-length entries.
    base = issued;
    rdy_mode = 0;
    push(32'h0000_4000, mk_hi(1, 0, 2'b00, 8'h01), 0);
    push(32'h0000_5000, mk_hi(0, 0, 2'b01, 8'h02), 1);
    repeat (10) @(negedge clk);
    check(issued == base, "R4 no reads for zero length", 64'(issued), 64'(base));
    check(ent_ready_o == 1 && word_valid_o == 0, "R4 queue emptied, no word",
          {62'h0, ent_ready_o, word_valid_o}, 64'h2);

    // R7 and R12: read ahead while downstream stalls.
    base = issued;
    push(32'h0001_0000, mk_hi(0, 5, 2'b00, 8'h10), 0);
    push(32'h0002_0000, mk_hi(0, 7, 2'b00, 8'h10), 1);
    repeat (60) @(negedge clk);
    check(issued - base == DATA_DEPTH + 1, "R7 read-ahead depth", 64'(issued - base), 64'(DATA_DEPTH + 1));
    rdy_mode = 1;
    wait_drain();

    // R6: sync entry closes its batch, next batch reads ahead again.
    rdy_mode = 0;
    base = issued;
    push(32'h0003_0000, mk_hi(1, 2, 2'b00, 8'h22), 1);
    push(32'h0004_0000, mk_hi(0, 3, 2'b00, 8'h22), 1);
    repeat (40) @(negedge clk);
    check(issued - base == 5 && delivered < issued, "R6 new batch reads ahead",
          64'(issued - base), 64'd5);
    rdy_mode = 2;
    push(32'h0005_0000, mk_hi(0, 3, 2'b00, 8'h30), 0);
    push(32'h0006_0000, mk_hi(1, 2, 2'b00, 8'h30), 0);
    push(32'h0007_0000, mk_hi(0, 4, 2'b00, 8'h30), 1);
    wait_drain();

    // R8 and R11: halt holds entries in the queue; queue fills.
    halt_i = 1'b1;
    base = issued;
    for (int k = 0; k < ENT_DEPTH; k++)
      push(32'(32'h0008_0000 + k * 32'h100), mk_hi(0, 3, 2'b00, 8'h40), k == ENT_DEPTH - 1);
    repeat (20) @(negedge clk);
    check(issued == base, "R8 nothing started while halted", 64'(issued), 64'(base));
    check(ent_ready_o == 0, "R11 queue full", 64'(ent_ready_o), 0);
    halt_i = 1'b0;
    wait_drain();
    check(ent_ready_o == 1, "R11 queue drained", 64'(ent_ready_o), 1);

    // R8: halt mid-segment lets the segment finish only.
    base = issued;
    push(32'h0009_0000, mk_hi(0, 6, 2'b00, 8'h50), 0);
    push(32'h000A_0000, mk_hi(0, 2, 2'b00, 8'h50), 1);
    while (issued == base) @(negedge clk);
    halt_i = 1'b1;
    repeat (40) @(negedge clk);
    check(issued - base == 6, "R8 segment completes under halt", 64'(issued - base), 64'd6);
    halt_i = 1'b0;
    wait_drain();
    check(issued - base == 8, "R8 resume after halt", 64'(issued - base), 64'd8);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule